// File: doc/BRIEF.md
# Bus-Turnaround Timing Controller

This block runs the low-power bus turnaround that follows a read on a serial display link. It watches a strobe that marks the end of each transmitted packet, together with that packet's 6-bit data type and its first payload byte. A packet that expects an answer from the panel starts the sequence. The block first waits a programmed number of escape-clock ticks, then holds a turnaround request toward the physical layer.

While the request is held, the block times how long the physical layer takes to change the bus direction. Once the receive side is active, it times how long the receiver goes without valid data. If either of these two limits runs out, a sticky error flag is set and the controller goes back to idle. If the receive data arrives in time, the block gives a one-cycle completion pulse.

All three counts are loaded when their phase begins. They step only on cycles that carry the escape-clock tick enable, so every interval is measured in escape-clock ticks and not in system clock cycles.

Top module: `dsi_turnaround_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `bta_req`, `ta_done`, `err_bta_to` and `err_rx_to` are all low.
- R2: A packet strobe starts the sequence when the data type is 0x04, 0x14, 0x24 or 0x06, whatever the command byte is. It also starts the sequence when the data type is 0x15 and the command byte is 0x35. Any other combination leaves the block idle.
- R3: The hold counter is loaded with `hold_cnt_cfg` on the clock edge that samples the starting strobe. Each later tick decrements it. `bta_req` goes high on the first edge at which the counter is found to be zero. With a tick on every cycle, `bta_req` is first seen high hold+2 cycles after the strobe is driven.
- R4: `bta_req` stays high until `rx_lpdt` is sampled high, or until the turnaround timeout expires. It goes low on the edge that samples either of these events.
- R5: On entering the request phase, a counter is loaded with `bta_to_cfg`. If `rx_lpdt` stays low for `bta_to_cfg`+1 ticks, `bta_req` drops and `err_bta_to` is set on the same edge.
- R6: On entering the receive phase, a counter is loaded with `rx_to_cfg`. If `rx_valid` stays low for `rx_to_cfg`+1 ticks, `err_rx_to` is set and the block returns to idle.
- R7: When `rx_valid` is sampled high in the receive phase, `ta_done` is high for exactly one cycle after that edge. The block is then idle.
- R8: `err_bta_to` and `err_rx_to` stay set until `err_clr` is sampled high, and that clears them. If a new error arrives in the same cycle as the clear, the flag stays set.
- R9: A packet strobe that arrives while a sequence is in progress is ignored. It starts no second sequence.
- R10: No counter moves on a cycle without `esc_tick`. With ticks stopped, the block stays in its current phase indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_sent | input | 1 | One-cycle strobe: a packet has finished transmitting |
| pkt_dtype | input | 6 | Data type of the packet that has just been sent |
| pkt_cmd | input | 8 | First payload byte (command) of that packet |
| esc_tick | input | 1 | Escape-clock tick enable |
| rx_lpdt | input | 1 | PHY indication that low-power receive is active |
| rx_valid | input | 1 | PHY receive data valid |
| hold_cnt_cfg | input | HOLD_W | Ticks between the packet end and the turnaround request |
| bta_to_cfg | input | BTA_W | Turnaround timeout count |
| rx_to_cfg | input | RXTO_W | Receive timeout count |
| err_clr | input | 1 | Clears both sticky error flags |
| bta_req | output | 1 | Turnaround request to the PHY |
| ta_done | output | 1 | One-cycle pulse when receive data has arrived |
| err_bta_to | output | 1 | Sticky turnaround timeout flag |
| err_rx_to | output | 1 | Sticky receive timeout flag |

## Verification
A wrong phase or a miscounted timer shows up at the ports within one cycle. It appears as a request that starts or ends one tick early or late, a missing or doubled completion pulse, or an error flag set in the wrong cycle. Because the reference model tracks the phase and the count on every cycle, a discrepancy is reported on the first clock at which the request, done or flag outputs diverge. A wrong trigger decode shows up as a request that appears, or fails to appear, within a few cycles of the strobe.

// File: rtl/dsi_ta_pkg.sv
package dsi_ta_pkg;

   typedef enum logic [2:0] {
      TA_IDLE = 3'd0,
      TA_HOLD = 3'd1,
      TA_BTA  = 3'd2,
      TA_RX   = 3'd3,
      TA_DONE = 3'd4
   } ta_state_e;

   localparam int DTYPE_W = 6;
   localparam int CMD_W   = 8;

   // packet types that expect a response from the peripheral
   localparam logic [DTYPE_W-1:0] DT_GRD_P0  = 6'h04;
   localparam logic [DTYPE_W-1:0] DT_GRD_P1  = 6'h14;
   localparam logic [DTYPE_W-1:0] DT_GRD_P2  = 6'h24;
   localparam logic [DTYPE_W-1:0] DT_DCS_RD  = 6'h06;
   // short command write carrying one parameter
   localparam logic [DTYPE_W-1:0] DT_DCS_WP  = 6'h15;
   localparam logic [CMD_W-1:0]   CMD_TEAR_ON = 8'h35;

endpackage

// File: rtl/dsi_ta_trigger.sv
module dsi_ta_trigger
   import dsi_ta_pkg::*;
#(
   parameter bit TEAR_EN = 1'b1
) (
   input  logic [DTYPE_W-1:0] dtype,
   input  logic [CMD_W-1:0]   cmd,
   output logic               fire
);

   logic is_read;
   logic is_tear;

   assign is_read = (dtype == DT_GRD_P0) || (dtype == DT_GRD_P1) ||
                    (dtype == DT_GRD_P2) || (dtype == DT_DCS_RD);

   generate
      if (TEAR_EN) begin : g_tear
         assign is_tear = (dtype == DT_DCS_WP) && (cmd == CMD_TEAR_ON);
      end else begin : g_no_tear
         logic unused_cmd;
         assign unused_cmd = ^cmd;
         assign is_tear    = 1'b0;
      end
   endgenerate

   assign fire = is_read | is_tear;

endmodule

// File: rtl/dsi_ta_downcnt.sv
module dsi_ta_downcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W < 1) begin : g_bad_width
         $error("dsi_ta_downcnt: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (dec && (cnt != '0)) begin
         cnt <= cnt - ONE;
      end
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/dsi_ta_fsm.sv
module dsi_ta_fsm
   import dsi_ta_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic esc_tick,
   input  logic rx_lpdt,
   input  logic rx_valid,
   input  logic err_clr,
   input  logic hold_zero,
   input  logic bta_zero,
   input  logic rx_zero,
   output logic ld_hold,
   output logic ld_bta,
   output logic ld_rx,
   output logic dec_hold,
   output logic dec_bta,
   output logic dec_rx,
   output logic bta_req,
   output logic ta_done,
   output logic err_bta_to,
   output logic err_rx_to
);

   ta_state_e st, nxt;
   logic      set_bta, set_rx;

   always_comb begin
      nxt      = st;
      ld_hold  = 1'b0;
      ld_bta   = 1'b0;
      ld_rx    = 1'b0;
      dec_hold = 1'b0;
      dec_bta  = 1'b0;
      dec_rx   = 1'b0;
      set_bta  = 1'b0;
      set_rx   = 1'b0;
      case (st)
         TA_IDLE: begin
            if (start) begin
               nxt     = TA_HOLD;
               ld_hold = 1'b1;
            end
         end
         TA_HOLD: begin
            if (hold_zero) begin
               nxt    = TA_BTA;
               ld_bta = 1'b1;
            end else begin
               dec_hold = esc_tick;
            end
         end
         TA_BTA: begin
            if (rx_lpdt) begin
               nxt   = TA_RX;
               ld_rx = 1'b1;
            end else if (esc_tick) begin
               if (bta_zero) begin
                  nxt     = TA_IDLE;
                  set_bta = 1'b1;
               end else begin
                  dec_bta = 1'b1;
               end
            end
         end
         TA_RX: begin
            if (rx_valid) begin
               nxt = TA_DONE;
            end else if (esc_tick) begin
               if (rx_zero) begin
                  nxt    = TA_IDLE;
                  set_rx = 1'b1;
               end else begin
                  dec_rx = 1'b1;
               end
            end
         end
         TA_DONE: nxt = TA_IDLE;
         default: nxt = TA_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= TA_IDLE;
         err_bta_to <= 1'b0;
         err_rx_to  <= 1'b0;
      end else begin
         st         <= nxt;
         err_bta_to <= set_bta | (err_bta_to & ~err_clr);
         err_rx_to  <= set_rx  | (err_rx_to  & ~err_clr);
      end
   end

   assign bta_req = (st == TA_BTA);
   assign ta_done = (st == TA_DONE);

endmodule

// File: rtl/dsi_turnaround_ctrl.sv
module dsi_turnaround_ctrl
   import dsi_ta_pkg::*;
#(
   parameter int HOLD_W  = 16,
   parameter int BTA_W   = 8,
   parameter int RXTO_W  = 16,
   parameter bit TEAR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_sent,
   input  logic [5:0]        pkt_dtype,
   input  logic [7:0]        pkt_cmd,
   input  logic              esc_tick,
   input  logic              rx_lpdt,
   input  logic              rx_valid,
   input  logic [HOLD_W-1:0] hold_cnt_cfg,
   input  logic [BTA_W-1:0]  bta_to_cfg,
   input  logic [RXTO_W-1:0] rx_to_cfg,
   input  logic              err_clr,
   output logic              bta_req,
   output logic              ta_done,
   output logic              err_bta_to,
   output logic              err_rx_to
);

   generate
      if (HOLD_W < 1 || BTA_W < 1 || RXTO_W < 1) begin : g_bad_cfg
         $error("dsi_turnaround_ctrl: counter widths must be positive");
      end
   endgenerate

   logic fire, start;
   logic ld_hold, ld_bta, ld_rx;
   logic dec_hold, dec_bta, dec_rx;
   logic hold_zero, bta_zero, rx_zero;

   dsi_ta_trigger #(.TEAR_EN(TEAR_EN)) u_trig (
      .dtype (pkt_dtype),
      .cmd   (pkt_cmd),
      .fire  (fire)
   );

   assign start = pkt_sent & fire;

   dsi_ta_downcnt #(.W(HOLD_W)) u_hold_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_hold),
      .load_val (hold_cnt_cfg),
      .dec      (dec_hold),
      .zero     (hold_zero)
   );

   dsi_ta_downcnt #(.W(BTA_W)) u_bta_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_bta),
      .load_val (bta_to_cfg),
      .dec      (dec_bta),
      .zero     (bta_zero)
   );

   dsi_ta_downcnt #(.W(RXTO_W)) u_rx_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_rx),
      .load_val (rx_to_cfg),
      .dec      (dec_rx),
      .zero     (rx_zero)
   );

   dsi_ta_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .esc_tick   (esc_tick),
      .rx_lpdt    (rx_lpdt),
      .rx_valid   (rx_valid),
      .err_clr    (err_clr),
      .hold_zero  (hold_zero),
      .bta_zero   (bta_zero),
      .rx_zero    (rx_zero),
      .ld_hold    (ld_hold),
      .ld_bta     (ld_bta),
      .ld_rx      (ld_rx),
      .dec_hold   (dec_hold),
      .dec_bta    (dec_bta),
      .dec_rx     (dec_rx),
      .bta_req    (bta_req),
      .ta_done    (ta_done),
      .err_bta_to (err_bta_to),
      .err_rx_to  (err_rx_to)
   );

endmodule

// File: rtl/dsi_ta_checker.sv
module dsi_ta_checker (
   input logic clk,
   input logic rst_n,
   input logic esc_tick,
   input logic rx_lpdt,
   input logic rx_valid,
   input logic err_clr,
   input logic bta_req,
   input logic ta_done,
   input logic err_bta_to,
   input logic err_rx_to
);

   // R7: completion is a single-cycle pulse
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ta_done |=> !ta_done);

   // R7: completion only follows valid receive data, never with a request
   p_done_after_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ta_done |-> ($past(rx_valid) && !bta_req));

   // R4: the request ends only on a direction change or on a tick
   p_req_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bta_req) |-> ($past(rx_lpdt) || $past(esc_tick)));

   // R10: with no tick and no direction change the request holds
   p_req_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bta_req && !esc_tick && !rx_lpdt) |=> bta_req);

   // R5: the turnaround error appears as the request is withdrawn
   p_bta_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_bta_to) |-> ($past(bta_req) && !bta_req));

   // R6: the receive error needs a tick without valid data
   p_rx_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_rx_to) |-> ($past(esc_tick) && !$past(rx_valid) && !bta_req));

   // R8: flags are sticky until cleared
   p_sticky_bta_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_bta_to && !err_clr) |=> err_bta_to);

   p_sticky_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_rx_to && !err_clr) |=> err_rx_to);

endmodule

bind dsi_turnaround_ctrl dsi_ta_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .esc_tick   (esc_tick),
   .rx_lpdt    (rx_lpdt),
   .rx_valid   (rx_valid),
   .err_clr    (err_clr),
   .bta_req    (bta_req),
   .ta_done    (ta_done),
   .err_bta_to (err_bta_to),
   .err_rx_to  (err_rx_to)
);

// File: tb/dsi_turnaround_ctrl_tb.sv
`timescale 1ns/1ps
module dsi_turnaround_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_sent = 1'b0;
   logic [5:0]  pkt_dtype = '0;
   logic [7:0]  pkt_cmd = '0;
   logic        esc_tick = 1'b0;
   logic        rx_lpdt = 1'b0;
   logic        rx_valid = 1'b0;
   logic [15:0] hold_cnt_cfg = '0;
   logic [7:0]  bta_to_cfg = '0;
   logic [15:0] rx_to_cfg = '0;
   logic        err_clr = 1'b0;
   logic        bta_req, ta_done, err_bta_to, err_rx_to;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int tcnt = 0;
   bit tick_on = 1'b1;
   int tick_div = 1;

   always #4 clk = ~clk;

   dsi_turnaround_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .pkt_sent(pkt_sent), .pkt_dtype(pkt_dtype),
      .pkt_cmd(pkt_cmd), .esc_tick(esc_tick), .rx_lpdt(rx_lpdt),
      .rx_valid(rx_valid), .hold_cnt_cfg(hold_cnt_cfg), .bta_to_cfg(bta_to_cfg),
      .rx_to_cfg(rx_to_cfg), .err_clr(err_clr), .bta_req(bta_req),
      .ta_done(ta_done), .err_bta_to(err_bta_to), .err_rx_to(err_rx_to)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // tick generator
   always @(negedge clk) begin
      tcnt++;
      esc_tick = tick_on && ((tcnt % tick_div) == 0);
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog (all) actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   // behavioural reference model: 0 idle,1 hold,2 request,3 receive,4 done
   int m_st = 0;
   int m_cnt = 0;
   bit m_eb = 0, m_er = 0;

   function automatic bit m_trig(input int t, input int c);
      return (t == 'h04) || (t == 'h14) || (t == 'h24) || (t == 'h06) ||
             ((t == 'h15) && (c == 'h35));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_eb = 0; m_er = 0;
      end else begin
         if (err_clr) begin m_eb = 0; m_er = 0; end
         case (m_st)
            0: if (pkt_sent && m_trig(pkt_dtype, pkt_cmd)) begin
                  m_st = 1; m_cnt = hold_cnt_cfg;
               end
            1: if (m_cnt == 0) begin m_st = 2; m_cnt = bta_to_cfg; end
               else if (esc_tick) m_cnt--;
            2: if (rx_lpdt) begin m_st = 3; m_cnt = rx_to_cfg; end
               else if (esc_tick) begin
                  if (m_cnt == 0) begin m_st = 0; m_eb = 1; end
                  else m_cnt--;
               end
            3: if (rx_valid) m_st = 4;
               else if (esc_tick) begin
                  if (m_cnt == 0) begin m_st = 0; m_er = 1; end
                  else m_cnt--;
               end
            default: m_st = 0;
         endcase
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(bta_req == (m_st == 2), "R4", "model bta_req", bta_req, m_st == 2);
         chk(ta_done == (m_st == 4), "R7", "model ta_done", ta_done, m_st == 4);
         chk(err_bta_to == m_eb, "R5", "model err_bta_to", err_bta_to, m_eb);
         chk(err_rx_to == m_er, "R6", "model err_rx_to", err_rx_to, m_er);
      end
   end

   task automatic send(input logic [5:0] t, input logic [7:0] c);
      @(negedge clk);
      pkt_sent = 1'b1; pkt_dtype = t; pkt_cmd = c;
      @(negedge clk);
      pkt_sent = 1'b0;
   endtask

   task automatic wait_req(input int maxn, output int n);
      n = 1;
      while (!bta_req && n < maxn) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic finish_ok(input string req);
      rx_lpdt = 1'b1;
      @(negedge clk);
      chk(bta_req == 1'b0, "R4", "req after direction change", bta_req, 0);
      rx_valid = 1'b1;
      @(negedge clk);
      chk(ta_done == 1'b1, req, "done pulse", ta_done, 1);
      rx_lpdt = 1'b0; rx_valid = 1'b0;
      @(negedge clk);
      chk(ta_done == 1'b0, "R7", "done single cycle", ta_done, 0);
   endtask

   task automatic expect_quiet(input int n, input string req, input string what);
      bit seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (bta_req) seen = 1;
      end
      chk(!seen, req, what, seen, 0);
   endtask

   initial begin
      int n;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk({bta_req, ta_done, err_bta_to, err_rx_to} == 4'b0, "R1", "outputs in reset",
          {bta_req, ta_done, err_bta_to, err_rx_to}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({bta_req, ta_done, err_bta_to, err_rx_to} == 4'b0, "R1", "outputs after reset",
          {bta_req, ta_done, err_bta_to, err_rx_to}, 0);

      // R3: hold interval with a tick on every cycle, generic read 0x04
      hold_cnt_cfg = 16'd3; bta_to_cfg = 8'd20; rx_to_cfg = 16'd20;
      send(6'h04, 8'h00);
      wait_req(40, n);
      chk(n == 5, "R3", "cycles to request (hold 3)", n, 5);
      finish_ok("R7");

      // R3: zero hold
      hold_cnt_cfg = 16'd0;
      send(6'h14, 8'h77);
      wait_req(40, n);
      chk(n == 2, "R3", "cycles to request (hold 0)", n, 2);
      finish_ok("R2");

      // R2: remaining read type
      send(6'h24, 8'h00);
      wait_req(40, n);
      chk(bta_req == 1'b1, "R2", "type 0x24 triggers", bta_req, 1);
      finish_ok("R2");

      // R5: turnaround timeout on a command read
      bta_to_cfg = 8'd2;
      send(6'h06, 8'h0a);
      wait_req(40, n);
      chk(bta_req == 1'b1, "R2", "type 0x06 triggers", bta_req, 1);
      repeat (2) @(negedge clk);
      chk(bta_req == 1'b1 && err_bta_to == 1'b0, "R5", "still waiting before expiry",
          {bta_req, err_bta_to}, 2);
      @(negedge clk);
      chk(err_bta_to == 1'b1, "R5", "turnaround error set", err_bta_to, 1);
      chk(bta_req == 1'b0, "R5", "request withdrawn", bta_req, 0);

      // R8: sticky until cleared
      repeat (10) @(negedge clk);
      chk(err_bta_to == 1'b1, "R8", "error stays set", err_bta_to, 1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk(err_bta_to == 1'b0, "R8", "error cleared", err_bta_to, 0);

      // R2 + R6: set-tear-on triggers, receive timeout
      rx_to_cfg = 16'd3; bta_to_cfg = 8'd20;
      send(6'h15, 8'h35);
      wait_req(40, n);
      chk(bta_req == 1'b1, "R2", "tear-on write triggers", bta_req, 1);
      rx_lpdt = 1'b1;
      repeat (4) @(negedge clk);
      chk(err_rx_to == 1'b0, "R6", "no error before expiry", err_rx_to, 0);
      @(negedge clk);
      chk(err_rx_to == 1'b1, "R6", "receive error set", err_rx_to, 1);
      chk(ta_done == 1'b0, "R6", "no done on timeout", ta_done, 0);
      rx_lpdt = 1'b0;
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk(err_rx_to == 1'b0, "R8", "receive error cleared", err_rx_to, 0);

      // R2: non-triggering packets
      send(6'h15, 8'h29);
      expect_quiet(20, "R2", "0x15 with other command");
      send(6'h05, 8'h35);
      expect_quiet(20, "R2", "0x05 with 0x35");
      send(6'h39, 8'h35);
      expect_quiet(20, "R2", "long write");

      // R10: no ticks, no progress
      hold_cnt_cfg = 16'd2;
      tick_on = 1'b0;
      send(6'h04, 8'h00);
      expect_quiet(30, "R10", "hold frozen without ticks");
      tick_on = 1'b1;
      wait_req(20, n);
      chk(bta_req == 1'b1, "R10", "resumes with ticks", bta_req, 1);
      finish_ok("R7");

      // R9: strobe while busy is ignored
      hold_cnt_cfg = 16'd1;
      send(6'h04, 8'h00);
      wait_req(40, n);
      send(6'h06, 8'h00);
      chk(bta_req == 1'b1, "R9", "request held through strobe", bta_req, 1);
      finish_ok("R7");
      expect_quiet(30, "R9", "no second sequence");

      // R5 with sparse ticks (model tracks exact timing)
      tick_div = 3; hold_cnt_cfg = 16'd5; bta_to_cfg = 8'd4;
      send(6'h24, 8'h00);
      repeat (60) @(negedge clk);
      chk(err_bta_to == 1'b1, "R5", "timeout with sparse ticks", err_bta_to, 1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      tick_div = 1;
      repeat (5) @(negedge clk);

      finish_run();
   end

endmodule